// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block fronts a one-time-programmable store of 64 words of 32 bits. Neighbouring even and odd word addresses form one pair: the odd word is a shadow that always holds the same bits as its even partner. Software drives the block through a small register port. It writes a word address, write data and a pulse length. It then writes a command code into the control register and polls the state field until the machine is idle again.

There are three commands. Sense walks the whole array and copies every pair into a readable snapshot bank. Read captures one snapshot word into the read-data register. Program holds a burn pulse for a programmable number of clock cycles and then ORs the write data into the addressed pair. Fuse bits can only go from 0 to 1. A program command burns nothing when any of these holds: the permanent disable lock is nonzero, the write-access register is nonzero, or power-good is low. Reset models a blank part: every fuse reads 0.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset the control register (offset 0x00) reads 0x0004_0000, meaning state code 4 (idle) in bits [19:16] and sense-done (bit 30) clear. Read data (0x08) reads 0. Write access (0x30) reads 1.
- R2: A read command (code 1 in control bits [1:0]) captures the snapshot word of the pair named by the address register (0x04) into read data. Before any sense pass, every snapshot word is 0.
- R3: The control register reports state code 1 for read, 2 for program and 3 for sense while that command runs. It reports 4 when idle.
- R4: A permitted program command (code 2) ORs write data (0x0C) into the addressed pair. After a sense pass, the even address and the odd address of that pair both return the accumulated value, and no bit ever returns to 0.
- R5: A program command burns nothing, but still runs and returns to idle, when power-good (0x34 bit 0) is 0, when write access (0x30 bit 0) is 1, or when the disable lock (0x2C) is nonzero.
- R6: A program command keeps state code 2 for exactly max(P,1) cycles, where P is the program-time register (0x1C).
- R7: A sense command (code 3) keeps state code 3 for exactly 32 cycles, one per pair. It clears bit 30 when it starts and sets bit 30 when it finishes.
- R8: Read returns the snapshot from the last sense pass. A burn becomes visible only after the next sense.
- R9: A command written while the state is not idle is ignored.
- R10: Writes to the disable lock OR into it, so once it is nonzero it cannot be cleared.
- R11: Writes to write data (0x0C) and program time (0x1C) are ignored while write access is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |

## Verification
The bench burns overlapping patterns through both halves of a pair. A design that cleared bits, or updated only the even word, would return a different value at the odd address. It counts busy cycles for a program time of 7 and of 0. An off-by-one pulse counter, or a zero time that hangs the machine, shows up in that count. It reads back before and after a sense pass, which exposes a read path that bypasses the snapshot. It issues a program command in the middle of a sense pass and tries all three blocking conditions; a design that accepted the stray command or burned while gated would leave nonzero fuse bits behind.

// File: rtl/otp_pkg.sv
// Shared definitions for the fuse controller: state codes, command codes
// and register offsets. Assumes byte offsets on an 8-bit register address.
package otp_pkg;
    typedef enum logic [3:0] {
        ST_READ  = 4'd1,
        ST_PROG  = 4'd2,
        ST_SENSE = 4'd3,
        ST_IDLE  = 4'd4
    } otp_state_e;

    localparam logic [1:0] CMD_READ  = 2'd1;
    localparam logic [1:0] CMD_PROG  = 2'd2;
    localparam logic [1:0] CMD_SENSE = 2'd3;

    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_ADDR  = 8'h04;
    localparam logic [7:0] OFS_RDAT  = 8'h08;
    localparam logic [7:0] OFS_WDAT  = 8'h0C;
    localparam logic [7:0] OFS_PTIME = 8'h1C;
    localparam logic [7:0] OFS_LOCK  = 8'h2C;
    localparam logic [7:0] OFS_WACC  = 8'h30;
    localparam logic [7:0] OFS_PWRG  = 8'h34;
endpackage

// File: rtl/otp_fuse_array.sv
// Behavioural set-only fuse store, one entry per fuse/shadow pair.
// Assumes: reset stands for a blank part; a burn may only OR bits in.
module otp_fuse_array #(
    parameter int NUM_PAIRS = 32,
    parameter int WORD_W    = 32,
    localparam int IDX_W    = $clog2(NUM_PAIRS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burn_en,
    input  logic [IDX_W-1:0]  burn_idx,
    input  logic [WORD_W-1:0] burn_bits,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_bits
);
    logic [WORD_W-1:0] mem_q [NUM_PAIRS];

    // Burn: OR new bits into the selected pair, never clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PAIRS; i++) mem_q[i] <= '0;
        end else if (burn_en) begin
            mem_q[burn_idx] <= mem_q[burn_idx] | burn_bits;
        end
    end

    // Sense read port.
    assign rd_bits = mem_q[rd_idx];

    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_chk
        a_r4_set_only: assert property (@(posedge clk) disable iff (!rst_n)
            ((mem_q[g] & $past(mem_q[g])) == $past(mem_q[g])));
        a_r5_untouched: assert property (@(posedge clk) disable iff (!rst_n)
            !(burn_en && burn_idx == IDX_W'(g)) |=> $stable(mem_q[g]));
    end
endmodule

// File: rtl/otp_snap_bank.sv
// Snapshot bank filled by sense passes; reads see only this copy.
// Assumes one write per cycle from the sequencer.
module otp_snap_bank #(
    parameter int NUM_PAIRS = 32,
    parameter int WORD_W    = 32,
    localparam int IDX_W    = $clog2(NUM_PAIRS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_bits,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_bits
);
    logic [WORD_W-1:0] snap_q [NUM_PAIRS];

    // Store one sensed pair per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PAIRS; i++) snap_q[i] <= '0;
        end else if (wr_en) begin
            snap_q[wr_idx] <= wr_bits;
        end
    end

    assign rd_bits = snap_q[rd_idx];
endmodule

// File: rtl/otp_seq.sv
// Command sequencer: read (1 cycle), timed program pulse, sense walk.
// Assumes cmd_go is a one-cycle strobe; it is dropped unless idle.
module otp_seq
    import otp_pkg::*;
#(
    parameter int NUM_PAIRS = 32,
    parameter int PTIME_W   = 16,
    localparam int IDX_W    = $clog2(NUM_PAIRS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_go,
    input  logic [1:0]         cmd_code,
    input  logic [PTIME_W-1:0] ptime,
    input  logic               prog_ok,
    output otp_state_e         state,
    output logic               sense_done,
    output logic               burn_en,
    output logic               snap_we,
    output logic [IDX_W-1:0]   walk_idx,
    output logic               rd_capture
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PAIRS - 1);

    logic [PTIME_W-1:0] cnt_q, limit_q;
    logic               ok_q;
    logic               pulse_end;

    assign pulse_end = (cnt_q == limit_q - PTIME_W'(1));

    // State machine and pulse / walk counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cnt_q      <= '0;
            limit_q    <= PTIME_W'(1);
            ok_q       <= 1'b0;
            walk_idx   <= '0;
            sense_done <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (cmd_go) begin
                    unique case (cmd_code)
                        CMD_READ: state <= ST_READ;
                        CMD_PROG: begin
                            state   <= ST_PROG;
                            cnt_q   <= '0;
                            limit_q <= (ptime == '0) ? PTIME_W'(1) : ptime;
                            ok_q    <= prog_ok;
                        end
                        CMD_SENSE: begin
                            state      <= ST_SENSE;
                            walk_idx   <= '0;
                            sense_done <= 1'b0;
                        end
                        default: state <= ST_IDLE;
                    endcase
                end
                ST_READ: state <= ST_IDLE;
                ST_PROG: begin
                    if (pulse_end) state <= ST_IDLE;
                    else           cnt_q <= cnt_q + PTIME_W'(1);
                end
                ST_SENSE: begin
                    if (walk_idx == LAST_IDX) begin
                        state      <= ST_IDLE;
                        sense_done <= 1'b1;
                    end else begin
                        walk_idx <= walk_idx + IDX_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Per-state strobes to the storage.
    assign burn_en    = (state == ST_PROG) && pulse_end && ok_q;
    assign snap_we    = (state == ST_SENSE);
    assign rd_capture = (state == ST_READ);

    a_r3_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
        state inside {ST_READ, ST_PROG, ST_SENSE, ST_IDLE});
    a_r6_pulse_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG && !pulse_end) |=> state == ST_PROG);
    a_r7_done_from_sense: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sense_done) |-> $past(state) == ST_SENSE);
    a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SENSE && walk_idx != LAST_IDX && cmd_go) |=> state == ST_SENSE);
endmodule

// File: rtl/otp_fuse_ctrl.sv
// Top: register decode around the sequencer, fuse store and snapshot bank.
// Assumes byte-offset register access, reads are combinational.
module otp_fuse_ctrl
    import otp_pkg::*;
#(
    parameter int NUM_WORDS = 64,
    parameter int WORD_W    = 32,
    parameter int PTIME_W   = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata
);
    localparam int NUM_PAIRS = NUM_WORDS / 2;
    localparam int ADDR_W    = $clog2(NUM_WORDS);
    localparam int IDX_W     = $clog2(NUM_PAIRS);

    logic [ADDR_W-1:0]  addr_q;
    logic [WORD_W-1:0]  wdat_q, rdat_q, lock_q;
    logic [PTIME_W-1:0] ptime_q;
    logic               wacc_q, pwrg_q;
    logic               wr, cmd_go, prog_ok;
    otp_state_e         state;
    logic               sense_done, burn_en, snap_we, rd_capture;
    logic [IDX_W-1:0]   walk_idx;
    logic [WORD_W-1:0]  fuse_bits, snap_bits;

    assign wr      = bus_en && bus_we;
    assign cmd_go  = wr && (bus_addr == OFS_CTRL) && (bus_wdata[1:0] != 2'd0);
    assign prog_ok = (lock_q == '0) && !wacc_q && pwrg_q;

    // Register writes and read-data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdat_q  <= '0;
            rdat_q  <= '0;
            lock_q  <= '0;
            ptime_q <= '0;
            wacc_q  <= 1'b1;
            pwrg_q  <= 1'b0;
        end else begin
            if (wr && bus_addr == OFS_ADDR)  addr_q <= bus_wdata[ADDR_W-1:0];
            if (wr && bus_addr == OFS_WDAT  && !wacc_q) wdat_q  <= bus_wdata[WORD_W-1:0];
            if (wr && bus_addr == OFS_PTIME && !wacc_q) ptime_q <= bus_wdata[PTIME_W-1:0];
            if (wr && bus_addr == OFS_LOCK)  lock_q <= lock_q | bus_wdata[WORD_W-1:0];
            if (wr && bus_addr == OFS_WACC)  wacc_q <= bus_wdata[0];
            if (wr && bus_addr == OFS_PWRG)  pwrg_q <= bus_wdata[0];
            if (rd_capture) rdat_q <= snap_bits;
        end
    end

    // Register read mux.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_CTRL:  bus_rdata = {1'b0, sense_done, 10'd0, state, 16'd0};
            OFS_ADDR:  bus_rdata = 32'(addr_q);
            OFS_RDAT:  bus_rdata = 32'(rdat_q);
            OFS_WDAT:  bus_rdata = 32'(wdat_q);
            OFS_PTIME: bus_rdata = 32'(ptime_q);
            OFS_LOCK:  bus_rdata = 32'(lock_q);
            OFS_WACC:  bus_rdata = {31'd0, wacc_q};
            OFS_PWRG:  bus_rdata = {31'd0, pwrg_q};
            default:   bus_rdata = '0;
        endcase
    end

    otp_seq #(.NUM_PAIRS(NUM_PAIRS), .PTIME_W(PTIME_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_code(bus_wdata[1:0]),
        .ptime(ptime_q), .prog_ok(prog_ok), .state(state),
        .sense_done(sense_done), .burn_en(burn_en), .snap_we(snap_we),
        .walk_idx(walk_idx), .rd_capture(rd_capture)
    );

    otp_fuse_array #(.NUM_PAIRS(NUM_PAIRS), .WORD_W(WORD_W)) u_fuse (
        .clk(clk), .rst_n(rst_n), .burn_en(burn_en),
        .burn_idx(addr_q[ADDR_W-1:1]), .burn_bits(wdat_q),
        .rd_idx(walk_idx), .rd_bits(fuse_bits)
    );

    otp_snap_bank #(.NUM_PAIRS(NUM_PAIRS), .WORD_W(WORD_W)) u_snap (
        .clk(clk), .rst_n(rst_n), .wr_en(snap_we), .wr_idx(walk_idx),
        .wr_bits(fuse_bits), .rd_idx(addr_q[ADDR_W-1:1]), .rd_bits(snap_bits)
    );

    a_r10_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q != '0) |=> (lock_q != '0));
    a_r2_capture_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rd_capture |=> state == ST_IDLE);
endmodule

// File: tb/tb_otp_fuse_ctrl.sv
module tb_otp_fuse_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_chk = 0;
    int n_fail = 0;

    otp_fuse_ctrl dut (.*);

    always #10 clk = ~clk;

    // Vector table: word address, burn data, expected pair value after sense.
    localparam int NV = 6;
    localparam logic [5:0]  V_ADDR [NV] = '{6'd4, 6'd5, 6'd4, 6'd63, 6'd62, 6'd0};
    localparam logic [31:0] V_DATA [NV] = '{32'h0000_00F0, 32'h0000_0F00, 32'h0,
                                           32'h8000_0001, 32'h7FFF_FFFE, 32'hA5A5_0000};
    localparam logic [31:0] V_EXP  [NV] = '{32'h0000_00F0, 32'h0000_0FF0, 32'h0000_0FF0,
                                           32'h8000_0001, 32'hFFFF_FFFF, 32'hA5A5_0000};

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_en = 1'b0; bus_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 2000; i++) begin
            bus_read(8'h00, v);
            if (v[19:16] == 4'd4) break;
            @(negedge clk);
        end
    endtask

    task automatic do_cmd(input logic [1:0] c);
        bus_write(8'h00, {30'd0, c});
        wait_idle();
    endtask

    task automatic count_busy(input logic [1:0] c, output int n);
        logic [31:0] v;
        bus_write(8'h00, {30'd0, c});
        n = 0;
        for (int i = 0; i < 2000; i++) begin
            bus_read(8'h00, v);
            if (v[19:16] != {2'b00, c}) break;
            n++;
            @(negedge clk);
        end
    endtask

    task automatic burn(input logic [5:0] a, input logic [31:0] d);
        bus_write(8'h04, {26'd0, a});
        bus_write(8'h0C, d);
        do_cmd(2'd2);
    endtask

    task automatic fetch(input logic [5:0] a, output logic [31:0] v);
        bus_write(8'h04, {26'd0, a});
        do_cmd(2'd1);
        bus_read(8'h08, v);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(8'h00, v); chk("R1 ctrl", v, 32'h0004_0000);
        bus_read(8'h08, v); chk("R1 rdata", v, 32'h0);
        bus_read(8'h30, v); chk("R1 wacc", v, 32'h1);

        // R2 / R3 read before any sense; state 1 while reading
        bus_write(8'h04, 32'd9);
        bus_write(8'h00, 32'd1);
        bus_read(8'h00, v); chk("R3 read state", {28'd0, v[19:16]}, 32'd1);
        wait_idle();
        bus_read(8'h08, v); chk("R2 unsensed zero", v, 32'h0);

        // R11 write data ignored while write access is 1
        bus_write(8'h0C, 32'h1234);
        bus_read(8'h0C, v); chk("R11 wdata gated", v, 32'h0);

        bus_write(8'h30, 32'd0);
        bus_write(8'h34, 32'd1);
        bus_write(8'h1C, 32'd5);

        // R4 vector table walk
        for (int i = 0; i < NV; i++) begin
            burn(V_ADDR[i], V_DATA[i]);
            do_cmd(2'd3);
            fetch({V_ADDR[i][5:1], 1'b0}, v); chk("R4 even word", v, V_EXP[i]);
            fetch({V_ADDR[i][5:1], 1'b1}, v); chk("R4 odd shadow", v, V_EXP[i]);
        end

        // R7 sense duration and done flag
        bus_read(8'h00, v); chk("R7 done set", {31'd0, v[30]}, 32'd1);
        bus_write(8'h00, 32'd3);
        bus_read(8'h00, v);
        chk("R7 done cleared", {31'd0, v[30]}, 32'd0);
        chk("R3 sense state", {28'd0, v[19:16]}, 32'd3);
        wait_idle();
        count_busy(2'd3, n); chk("R7 sense cycles", n, 32'd32);

        // R6 pulse length
        bus_write(8'h04, 32'd40);
        bus_write(8'h1C, 32'd7);
        count_busy(2'd2, n); chk("R6 pulse 7", n, 32'd7);
        bus_write(8'h1C, 32'd0);
        count_busy(2'd2, n); chk("R6 pulse 0", n, 32'd1);
        bus_write(8'h1C, 32'd5);

        // R9 program request during a sense pass is dropped
        bus_write(8'h04, 32'd20);
        bus_write(8'h0C, 32'h0000_0011);
        bus_write(8'h00, 32'd3);
        bus_write(8'h00, 32'd2);
        wait_idle();
        bus_read(8'h00, v); chk("R9 idle after sense", {28'd0, v[19:16]}, 32'd4);
        do_cmd(2'd3);
        fetch(6'd20, v); chk("R9 no stray burn", v, 32'h0);

        // R8 read shows the snapshot, not the live array
        burn(6'd20, 32'h0000_0011);
        fetch(6'd20, v); chk("R8 stale before sense", v, 32'h0);
        do_cmd(2'd3);
        fetch(6'd21, v); chk("R8 visible after sense", v, 32'h0000_0011);

        // R5 power-good low
        bus_write(8'h34, 32'd0);
        burn(6'd30, 32'h0000_00FF);
        bus_read(8'h00, v); chk("R5 pg idle", {28'd0, v[19:16]}, 32'd4);
        bus_write(8'h34, 32'd1);
        do_cmd(2'd3);
        fetch(6'd30, v); chk("R5 pg blocks", v, 32'h0);

        // R5 write access set
        bus_write(8'h04, 32'd30);
        bus_write(8'h0C, 32'h0000_00F0);
        bus_write(8'h30, 32'd1);
        do_cmd(2'd2);
        bus_write(8'h30, 32'd0);
        do_cmd(2'd3);
        fetch(6'd30, v); chk("R5 wacc blocks", v, 32'h0);

        // R10 lock is sticky; R5 lock blocks
        bus_write(8'h2C, 32'd1);
        bus_write(8'h2C, 32'd0);
        bus_read(8'h2C, v); chk("R10 lock sticky", v, 32'h1);
        burn(6'd30, 32'h0000_0003);
        do_cmd(2'd3);
        fetch(6'd31, v); chk("R5 lock blocks", v, 32'h0);
        fetch(6'd4, v); chk("R4 earlier bits kept", v, 32'h0000_0FF0);

        finish_run();
    end
endmodule